// File: doc/BRIEF.md
# Condition Flag Register and Predicate Evaluator

This block sits in the execute stage of a 32-bit processor. Each cycle it receives two operands and an operation select (add, subtract or compare), forms the sum or difference, and derives the negative, zero, carry and overflow flags from that result. The flags are written into a four-bit state register on the clock edge when the instruction asks for a flag update.

A compare behaves like a subtract whose result is thrown away: it always updates the flags and never requests a register write. For subtraction and compare the carry flag is the inverse of a borrow, so it reads 1 when the first operand is greater than or equal to the second as unsigned numbers.

A 4-bit condition field is checked against the flags already held in the register. This check happens in the same cycle, without a clock edge. The resulting pass signal gates both the destination write and the flag update of a predicated instruction. It also serves as the taken signal for a conditional branch. Fifteen named conditions are supported, covering equality, single-flag tests, and signed and unsigned magnitude comparisons.

Top module: `cond_flag_unit`

## Requirements
- R1: An active-low asynchronous reset clears all four flags, so `flags_o` reads 4'b0000.
- R2: For add (`op_i` 2'b00, or 2'b11, which behaves the same), `result_o` is `a_i + b_i` modulo 2^32. When the flags are updated: N is bit 31 of the result; Z is 1 when all 32 result bits are zero; C is the carry out of bit 31; V is 1 when the signed sum overflows.
- R3: For subtract (`op_i` 2'b01) and compare (2'b10), `result_o` is `a_i - b_i` modulo 2^32. An update then sets N and Z from the difference as in R2, sets C to 1 exactly when `a_i >= b_i` unsigned (no borrow), and sets V when the signed difference overflows.
- R4: A compare updates all four flags whenever its condition passes, whatever `set_flags_i` is, and it never asserts `wr_en_o`.
- R5: When `set_flags_i` is 0 and the operation is not a compare, the flags keep their value across the clock edge.
- R6: Condition codes 0000 to 0111 pass respectively when Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R7: Condition codes 1000 to 1101 pass respectively when (C=1 and Z=0), (C=0 or Z=1), N==V, N!=V, (Z=0 and N==V), (Z=1 or N!=V).
- R8: Code 1110 always passes; code 1111 never passes.
- R9: `cond_pass_o` is combinational and uses the flags held before the current operation, not the flags that operation produces.
- R10: When the condition fails, `wr_en_o` is 0 and the flags stay unchanged, even if an update was requested.
- R11: `flags_o` carries the flags in the order N, Z, C, V, from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | 00 add, 01 subtract, 10 compare, 11 add |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (register or immediate) |
| set_flags_i | input | 1 | Request a flag update for add or subtract |
| cond_i | input | 4 | Condition field of the current instruction |
| result_o | output | 32 | Sum or difference |
| wr_en_o | output | 1 | Destination register write permitted |
| cond_pass_o | output | 1 | Condition holds against the stored flags |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The assertions assume that a new instruction is presented on every cycle and that the inputs settle before each rising edge. They also assume that no input is X or Z while reset is released. The bench meets these conditions by changing all inputs only on the falling edge, starting from zeros during reset, and drawing opcodes only from the four defined encodings. Operands mix boundary values with random words, so that carry, borrow and signed-overflow cases occur often while each assumption still holds.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_ADDX = 2'b11
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam int unsigned COND_W   = 4;
  localparam int unsigned NUM_COND = 1 << COND_W;

  localparam logic [COND_W-1:0] CC_EQ = 4'h0;
  localparam logic [COND_W-1:0] CC_NE = 4'h1;
  localparam logic [COND_W-1:0] CC_HS = 4'h2;
  localparam logic [COND_W-1:0] CC_LO = 4'h3;
  localparam logic [COND_W-1:0] CC_MI = 4'h4;
  localparam logic [COND_W-1:0] CC_PL = 4'h5;
  localparam logic [COND_W-1:0] CC_VS = 4'h6;
  localparam logic [COND_W-1:0] CC_VC = 4'h7;
  localparam logic [COND_W-1:0] CC_HI = 4'h8;
  localparam logic [COND_W-1:0] CC_LS = 4'h9;
  localparam logic [COND_W-1:0] CC_GE = 4'hA;
  localparam logic [COND_W-1:0] CC_LT = 4'hB;
  localparam logic [COND_W-1:0] CC_GT = 4'hC;
  localparam logic [COND_W-1:0] CC_LE = 4'hD;
  localparam logic [COND_W-1:0] CC_AL = 4'hE;
  localparam logic [COND_W-1:0] CC_NV = 4'hF;
endpackage

// File: rtl/cfu_adder.sv
module cfu_adder
  import cfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output flags_t            flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff = sub_i ? ~b_i : b_i;
  // subtract as a + ~b + 1; carry out then means no borrow
  assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o = wide[MSB:0];

  always_comb begin
    flags_o.n = wide[MSB];
    flags_o.z = ~|wide[MSB:0];
    flags_o.c = wide[DATA_W];
    flags_o.v = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
  import cfu_pkg::*;
(
  input  flags_t              flags_i,
  input  logic [COND_W-1:0]   cond_i,
  output logic                pass_o
);
  logic [NUM_COND-1:0] hit;
  logic                sgn_ge;

  assign sgn_ge = (flags_i.n == flags_i.v);

  always_comb begin
    hit        = '0;
    hit[CC_EQ] =  flags_i.z;
    hit[CC_NE] = ~flags_i.z;
    hit[CC_HS] =  flags_i.c;
    hit[CC_LO] = ~flags_i.c;
    hit[CC_MI] =  flags_i.n;
    hit[CC_PL] = ~flags_i.n;
    hit[CC_VS] =  flags_i.v;
    hit[CC_VC] = ~flags_i.v;
    hit[CC_HI] =  flags_i.c & ~flags_i.z;
    hit[CC_LS] = ~flags_i.c |  flags_i.z;
    hit[CC_GE] =  sgn_ge;
    hit[CC_LT] = ~sgn_ge;
    hit[CC_GT] = ~flags_i.z &  sgn_ge;
    hit[CC_LE] =  flags_i.z | ~sgn_ge;
    hit[CC_AL] = 1'b1;
    hit[CC_NV] = 1'b0;
  end

  assign pass_o = hit[cond_i];
endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
  import cfu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (upd_i) q_o <= d_i;
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              set_flags_i,
  input  logic [3:0]        cond_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              cond_pass_o,
  output logic [3:0]        flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  op_e    op;
  logic   is_sub, is_cmp, upd;
  flags_t flags_new, flags_q;

  assign op     = op_e'(op_i);
  assign is_cmp = (op == OP_CMP);
  assign is_sub = (op == OP_SUB) || is_cmp;

  cfu_adder #(.DATA_W(DATA_W)) u_adder (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (is_sub),
    .sum_o   (result_o),
    .flags_o (flags_new)
  );

  cfu_cond_eval u_cond (
    .flags_i (flags_q),
    .cond_i  (cond_i),
    .pass_o  (cond_pass_o)
  );

  // predicated: a failed condition blocks both write and flag update
  assign upd     = cond_pass_o && (set_flags_i || is_cmp);
  assign wr_en_o = cond_pass_o && !is_cmp;

  cfu_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .d_i    (flags_new),
    .q_o    (flags_q)
  );

  assign flags_o = flags_q;

  // R5 R10
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cond_pass_o || (!set_flags_i && op_i != 2'b10)) |=> $stable(flags_o));

  // R2
  neg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_pass_o && (set_flags_i || op_i == 2'b10)) |=> (flags_o[3] == $past(result_o[MSB])));

  // R2
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_pass_o && (set_flags_i || op_i == 2'b10)) |=> (flags_o[2] == ($past(result_o) == '0)));

  // R3
  borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_pass_o && (op_i == 2'b10 || (op_i == 2'b01 && set_flags_i)))
      |=> (flags_o[1] == ($past(a_i) >= $past(b_i))));

  // R4
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b10) |-> !wr_en_o);

  // R10
  fail_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_pass_o |-> !wr_en_o);

  // R8
  always_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'hE) |-> cond_pass_o);

  // R8
  never_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'hF) |-> !cond_pass_o);
endmodule

// File: tb/cond_flag_unit_tb.sv
module cond_flag_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        set_flags_i = 1'b0;
  logic [3:0]  cond_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o, cond_pass_o;
  logic [3:0]  flags_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit [3:0] ref_f = 4'b0000;  // {N,Z,C,V}

  always #5 clk_i = ~clk_i;

  cond_flag_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .set_flags_i(set_flags_i), .cond_i(cond_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .cond_pass_o(cond_pass_o), .flags_o(flags_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_pass(bit [3:0] f, bit [3:0] c);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic sf, input logic [3:0] cd, input string tag);
    bit [31:0] res;
    bit [3:0]  nf;
    bit        pass, cy, ov;
    longint    sv;
    string     ctag;
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; set_flags_i = sf; cond_i = cd;
    #1;
    pass = ref_pass(ref_f, cd);
    ctag = (cd < 8) ? "R6" : (cd < 14) ? "R7" : "R8";
    check(ctag, "cond_pass", {31'd0, cond_pass_o}, {31'd0, pass});
    if (op == 2'b01 || op == 2'b10) begin
      res = a - b;
      cy  = (a >= b);
      sv  = longint'($signed(a)) - longint'($signed(b));
    end else begin
      res = a + b;
      cy  = ({1'b0, a} + {1'b0, b}) > 33'hFFFF_FFFF;
      sv  = longint'($signed(a)) + longint'($signed(b));
    end
    ov = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
    nf = {res[31], res == 0, cy, ov};
    check(tag, "result", result_o, res);
    check(op == 2'b10 ? "R4" : "R10", "wr_en", {31'd0, wr_en_o},
          {31'd0, pass && op != 2'b10});
    if (pass && (sf || op == 2'b10)) ref_f = nf;
    @(posedge clk_i); #1;
    check(tag, "flags", {28'd0, flags_o}, {28'd0, ref_f});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", "flags after reset", {28'd0, flags_o}, 32'd0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2 add cases
    step(2'b00, 32'd1, 32'd2, 1, 4'hE, "R2");
    step(2'b00, 32'hFFFF_FFFF, 32'd1, 1, 4'hE, "R2");   // Z,C
    step(2'b11, 32'h7FFF_FFFF, 32'd1, 1, 4'hE, "R2");   // N,V
    check("R11", "flags order N..V", {28'd0, flags_o}, 32'h9);
    // R3 subtract / compare
    step(2'b01, 32'd5, 32'd5, 1, 4'hE, "R3");
    step(2'b10, 32'd3, 32'd5, 0, 4'hE, "R4");          // borrow
    step(2'b10, 32'h8000_0000, 32'd1, 0, 4'hE, "R3");  // signed overflow
    step(2'b01, 32'd0, 32'hFFFF_FFFF, 1, 4'hE, "R3");
    // R5 no update without set_flags
    step(2'b00, 32'd0, 32'd0, 0, 4'hE, "R5");
    step(2'b01, 32'd1, 32'd9, 0, 4'hE, "R5");
    // R8 never: no write, no flag update
    step(2'b00, 32'd0, 32'd0, 1, 4'hF, "R10");
    step(2'b10, 32'd7, 32'd7, 0, 4'hF, "R10");
    // R9: Z=1 held, EQ passes on old flags though new result is nonzero
    step(2'b10, 32'd4, 32'd4, 0, 4'hE, "R4");
    step(2'b01, 32'd9, 32'd2, 1, 4'h0, "R9");
    step(2'b00, 32'd9, 32'd2, 1, 4'h0, "R10");         // EQ now fails
    // sweep all conditions over several flag states
    for (int s = 0; s < 5; s++) begin
      case (s)
        0: step(2'b10, 32'd5, 32'd5, 0, 4'hE, "R4");
        1: step(2'b10, 32'd2, 32'd9, 0, 4'hE, "R4");
        2: step(2'b10, 32'd9, 32'd2, 0, 4'hE, "R4");
        3: step(2'b10, 32'h8000_0000, 32'd1, 0, 4'hE, "R4");
        default: step(2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 4'hE, "R4");
      endcase
      for (int c = 0; c < 16; c++)
        step(2'b00, 32'd1, 32'd1, 0, 4'(c), "R5");
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic [1:0]  rop;
      rop = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0: ra = 32'h8000_0000;
        1: ra = 32'h7FFF_FFFF;
        default: ra = $urandom;
      endcase
      rb = ($urandom_range(0, 3) == 0) ? ra : $urandom;
      step(rop, ra, rb, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
           (rop == 2'b00 || rop == 2'b11) ? "R2" : "R3");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule